// File: doc/BRIEF.md
# Set-Associative Tag and Permission Directory

This block keeps the tag and access-permission state for a set-associative cache. It also keeps the replacement order for that cache. It stores no data. A controller issues one command per cycle against a line address. The commands are: access check, presence test, availability test, allocate, deallocate, permission read, permission write, victim probe and touch.

Each result is registered and appears one cycle after its command. A result carries a hit flag, the selected way, a permission, a victim line address and an error flag. The set is chosen by the low bits of the line address. The whole line address is kept as the tag.

Each way carries one of four permission levels. The first is "absent", meaning the way holds no line. The second is "pending", the state a line takes when it has just been allocated and is not yet usable. The last two are "read-only" and "read-write". Replacement is true LRU, kept with one age counter per way in every set.

Top module: `tag_perm_dir`

## Requirements
- R1: The geometry and reset state are as follows.
  - There are 2**SET_BITS sets of WAYS ways each.
  - After reset, every way holds tag 0 with permission absent.
  - After reset, the LRU ages of a set equal the way indices, so the first victim is way WAYS-1.
- R2: Permissions are encoded as absent=0, pending=1, read-only=2 and read-write=3. Requests are encoded as load=0, fetch=1 and store=2. An access check (op 0) reports a hit in either of two cases:
  - the matching way is read-write, for any request;
  - the matching way is read-only and the request is a load or a fetch.
  A store to a read-only line misses.
- R3: A way matches only when its tag equals the address and its permission is not absent. An access check that matches a pending line misses. It still reports that way and marks it most recently used.
- R4: The availability test (op 2) is true under either of two conditions:
  - some way in the set holds the address, whatever its permission;
  - some way in the set is absent.
- R5: Allocate (op 3) works as follows.
  - It picks the lowest-numbered absent way.
  - It writes the address as the tag and sets the permission to pending.
  - It marks that way most recently used.
  - It reports that way.
- R6: Allocate raises the error flag and changes nothing in either of two cases: the set has no absent way, or the address already matches a way.
- R7: Deallocate (op 4) sets the matching way to absent. The stored tag is left as it was.
- R8: Permission write (op 6) stores cmd_perm_i into the matching way. Permission read (op 5) returns the permission of the matching way.
- R9: The victim probe (op 7) returns the oldest way of the set and that way's stored tag. Ties go to the lowest index.
- R10: Touch (op 8) marks the matching way most recently used.
- R11: Deallocate, permission read, permission write and touch raise the error flag when no way matches. In that case they change no state.
- R12: rsp_valid_o is high in exactly the cycle after a cycle with cmd_valid_i high.
- R13: The set index is the low SET_BITS bits of the line address. Sets do not share tags, permissions or LRU state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_op_i | input | 4 | Command code (0..8) |
| cmd_addr_i | input | ADDR_W | Line address |
| cmd_req_i | input | 2 | Request type for the access check |
| cmd_perm_i | input | 2 | New permission for a permission write |
| rsp_valid_o | output | 1 | Result valid |
| rsp_hit_o | output | 1 | Hit, present or available, depending on the command |
| rsp_way_o | output | WAY_W | Way selected by the command |
| rsp_perm_o | output | 2 | Permission of the selected way |
| rsp_victim_o | output | ADDR_W | Tag of the victim way on a probe |
| rsp_err_o | output | 1 | Command refused |

## Verification
The bench builds the block with SET_BITS=2, WAYS=4 and ADDR_W=12. With four ways, one set can be filled completely. That reaches the full-set allocate error and the availability test that relies only on a tag match. Four ways also give each touch a visible effect on which way the probe names next. With four sets, a second set can be used to show that filling set 0 leaves set 1 empty and still in its reset age order.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  typedef enum logic [1:0] {
    PERM_ABSENT  = 2'd0,
    PERM_PENDING = 2'd1,
    PERM_RDONLY  = 2'd2,
    PERM_RDWR    = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD  = 2'd0,
    REQ_FETCH = 2'd1,
    REQ_STORE = 2'd2
  } req_e;

  typedef enum logic [3:0] {
    OP_ACCESS  = 4'd0,
    OP_PRESENT = 4'd1,
    OP_AVAIL   = 4'd2,
    OP_ALLOC   = 4'd3,
    OP_DEALLOC = 4'd4,
    OP_PERM_RD = 4'd5,
    OP_PERM_WR = 4'd6,
    OP_PROBE   = 4'd7,
    OP_TOUCH   = 4'd8
  } op_e;
endpackage

// File: rtl/tpd_set_match.sv
module tpd_set_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16
) (
  input  logic [WAYS*ADDR_W-1:0] tags_i,
  input  logic [WAYS*2-1:0]      perms_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [WAYS-1:0]        present_o,
  output logic [WAYS-1:0]        same_tag_o,
  output logic [WAYS-1:0]        free_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic tag_eq;
    logic absent;
    assign tag_eq        = (tags_i[w*ADDR_W +: ADDR_W] == addr_i);
    assign absent        = (perms_i[w*2 +: 2] == 2'd0);
    assign same_tag_o[w] = tag_eq;
    assign free_o[w]     = absent;
    assign present_o[w]  = tag_eq && !absent;
  end
endmodule

// File: rtl/tpd_prio_enc.sv
module tpd_prio_enc #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpd_lru.sv
module tpd_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic [WAY_W-1:0] best_age;
    best_age = age_q[set_i][0];
    victim_o = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (age_q[set_i][w] > best_age) begin
        best_age = age_q[set_i][w];
        victim_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/tag_perm_dir.sv
module tag_perm_dir #(
  parameter int SET_BITS = 4,
  parameter int WAYS     = 4,
  parameter int ADDR_W   = 16,
  localparam int SETS    = 1 << SET_BITS,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [1:0]        cmd_req_i,
  input  logic [1:0]        cmd_perm_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [1:0]        rsp_perm_o,
  output logic [ADDR_W-1:0] rsp_victim_o,
  output logic              rsp_err_o
);
  import tpd_pkg::*;

  logic [ADDR_W-1:0] tag_q  [SETS][WAYS];
  logic [1:0]        perm_q [SETS][WAYS];

  logic [SET_BITS-1:0]    set_idx;
  logic [WAYS*ADDR_W-1:0] cur_tags;
  logic [WAYS*2-1:0]      cur_perms;
  logic [WAYS-1:0]        present_vec, same_vec, free_vec;
  logic [WAY_W-1:0]       hit_way, free_way, victim_way;
  logic                   any_present, any_free;
  logic [1:0]             hit_perm;

  assign set_idx = cmd_addr_i[SET_BITS-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_flat
    assign cur_tags[w*ADDR_W +: ADDR_W] = tag_q[set_idx][w];
    assign cur_perms[w*2 +: 2]          = perm_q[set_idx][w];
  end

  tpd_set_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) match_i (
    .tags_i(cur_tags), .perms_i(cur_perms), .addr_i(cmd_addr_i),
    .present_o(present_vec), .same_tag_o(same_vec), .free_o(free_vec)
  );

  tpd_prio_enc #(.N(WAYS), .IDX_W(WAY_W)) hit_enc_i (
    .vec_i(present_vec), .idx_o(hit_way), .any_o(any_present)
  );

  tpd_prio_enc #(.N(WAYS), .IDX_W(WAY_W)) free_enc_i (
    .vec_i(free_vec), .idx_o(free_way), .any_o(any_free)
  );

  logic             touch_en;
  logic [WAY_W-1:0] touch_way;

  tpd_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_BITS), .WAY_W(WAY_W)) lru_i (
    .clk(clk), .rst(rst), .touch_en_i(touch_en), .set_i(set_idx),
    .touch_way_i(touch_way), .victim_o(victim_way)
  );

  assign hit_perm = perm_q[set_idx][hit_way];

  logic              n_hit, n_err;
  logic [WAY_W-1:0]  n_way;
  logic [1:0]        n_perm;
  logic [ADDR_W-1:0] n_victim;
  logic              wr_tag, wr_perm;
  logic [WAY_W-1:0]  wr_way;
  logic [1:0]        wr_perm_val;

  always_comb begin
    n_hit       = 1'b0;
    n_err       = 1'b0;
    n_way       = hit_way;
    n_perm      = any_present ? hit_perm : 2'(PERM_ABSENT);
    n_victim    = '0;
    touch_en    = 1'b0;
    touch_way   = hit_way;
    wr_tag      = 1'b0;
    wr_perm     = 1'b0;
    wr_way      = hit_way;
    wr_perm_val = 2'(PERM_ABSENT);
    if (cmd_valid_i) begin
      case (cmd_op_i)
        4'(OP_ACCESS): begin
          if (any_present) begin
            touch_en = 1'b1;
            n_hit = (hit_perm == 2'(PERM_RDWR)) ||
                    ((hit_perm == 2'(PERM_RDONLY)) && (cmd_req_i != 2'(REQ_STORE)));
          end
        end
        4'(OP_PRESENT): n_hit = any_present;
        4'(OP_AVAIL):   n_hit = (|same_vec) || any_free;
        4'(OP_ALLOC): begin
          if (any_present || !any_free) begin
            n_err = 1'b1;
          end else begin
            wr_tag      = 1'b1;
            wr_perm     = 1'b1;
            wr_way      = free_way;
            wr_perm_val = 2'(PERM_PENDING);
            touch_en    = 1'b1;
            touch_way   = free_way;
            n_way       = free_way;
            n_perm      = 2'(PERM_PENDING);
          end
        end
        4'(OP_DEALLOC): begin
          if (!any_present) begin
            n_err = 1'b1;
          end else begin
            wr_perm     = 1'b1;
            wr_perm_val = 2'(PERM_ABSENT);
            n_perm      = 2'(PERM_ABSENT);
          end
        end
        4'(OP_PERM_RD): n_err = !any_present;
        4'(OP_PERM_WR): begin
          if (!any_present) begin
            n_err = 1'b1;
          end else begin
            wr_perm     = 1'b1;
            wr_perm_val = cmd_perm_i;
            n_perm      = cmd_perm_i;
          end
        end
        4'(OP_PROBE): begin
          n_way    = victim_way;
          n_victim = tag_q[set_idx][victim_way];
          n_perm   = perm_q[set_idx][victim_way];
        end
        4'(OP_TOUCH): begin
          if (!any_present) n_err = 1'b1;
          else              touch_en = 1'b1;
        end
        default: n_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          perm_q[s][w] <= 2'(PERM_ABSENT);
        end
    end else begin
      if (wr_tag)  tag_q[set_idx][wr_way]  <= cmd_addr_i;
      if (wr_perm) perm_q[set_idx][wr_way] <= wr_perm_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_way_o    <= '0;
      rsp_perm_o   <= '0;
      rsp_victim_o <= '0;
      rsp_err_o    <= 1'b0;
    end else begin
      rsp_valid_o  <= cmd_valid_i;
      rsp_hit_o    <= n_hit;
      rsp_way_o    <= n_way;
      rsp_perm_o   <= n_perm;
      rsp_victim_o <= n_victim;
      rsp_err_o    <= n_err;
    end
  end
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
  parameter int SET_BITS = 4,
  parameter int WAYS     = 4,
  parameter int ADDR_W   = 16,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_op_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [1:0]        cmd_req_i,
  input logic [1:0]        cmd_perm_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [WAY_W-1:0]  rsp_way_o,
  input logic [1:0]        rsp_perm_o,
  input logic [ADDR_W-1:0] rsp_victim_o,
  input logic              rsp_err_o
);
  assert_rsp_follows_cmd_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i |=> rsp_valid_o);

  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_i |=> !rsp_valid_o);

  assert_store_needs_rw_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 4'd0 && cmd_req_i == 2'd2) |=> (!rsp_hit_o || rsp_perm_o == 2'd3));

  assert_access_hit_readable_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 4'd0) |=> (!rsp_hit_o || rsp_perm_o[1]));

  assert_alloc_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 4'd3) |=> (rsp_err_o || rsp_perm_o == 2'd1));

  assert_probe_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 4'd7) |=> !rsp_err_o);

  assert_err_with_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_err_o |-> rsp_valid_o);
endmodule

bind tag_perm_dir tpd_checker #(.SET_BITS(SET_BITS), .WAYS(WAYS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/tag_perm_dir_tb_top.sv
module tag_perm_dir_tb_top;
  import tpd_pkg::*;
  localparam int SB = 2, NW = 4, AW = 12, WW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid_i = 1'b0;
  logic [3:0] cmd_op_i = '0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [1:0] cmd_req_i = '0, cmd_perm_i = '0;
  logic rsp_valid_o, rsp_hit_o, rsp_err_o;
  logic [WW-1:0] rsp_way_o;
  logic [1:0] rsp_perm_o;
  logic [AW-1:0] rsp_victim_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tag_perm_dir #(.SET_BITS(SB), .WAYS(NW), .ADDR_W(AW)) dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(op_e op, int addr, req_e rq = REQ_LOAD, perm_e pm = PERM_ABSENT);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = AW'(addr);
    cmd_req_i = rq; cmd_perm_i = pm;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk("R12 rsp_valid", int'(rsp_valid_o), 1);
  endtask

  task automatic probe_expect(string tag, int addr, int way, int vic);
    issue(OP_PROBE, addr);
    chk({tag, " way"}, int'(rsp_way_o), way);
    chk({tag, " victim"}, int'(rsp_victim_o), vic);
  endtask

  task automatic t_reset();
    chk("R12 idle after reset", int'(rsp_valid_o), 0);
    issue(OP_PRESENT, 'h004); chk("R1 empty present", int'(rsp_hit_o), 0);
    issue(OP_AVAIL, 'h004);   chk("R1 empty avail", int'(rsp_hit_o), 1);
    probe_expect("R1 reset victim", 'h004, 3, 'h000);
    @(negedge clk); chk("R12 idle", int'(rsp_valid_o), 0);
  endtask

  task automatic t_fill();
    int ad[4] = '{'h010, 'h020, 'h030, 'h040};
    for (int i = 0; i < 4; i++) begin
      issue(OP_ALLOC, ad[i]);
      chk("R5 alloc way", int'(rsp_way_o), i);
      chk("R5 alloc err", int'(rsp_err_o), 0);
      chk("R5 alloc perm pending", int'(rsp_perm_o), 1);
    end
    issue(OP_ALLOC, 'h050); chk("R6 full set err", int'(rsp_err_o), 1);
    issue(OP_PRESENT, 'h050); chk("R6 no install", int'(rsp_hit_o), 0);
    issue(OP_AVAIL, 'h050); chk("R4 full avail", int'(rsp_hit_o), 0);
    issue(OP_AVAIL, 'h020); chk("R4 tag avail", int'(rsp_hit_o), 1);
    probe_expect("R9 after fill", 'h050, 0, 'h010);
  endtask

  task automatic t_pending_touch();
    issue(OP_ACCESS, 'h010, REQ_LOAD);
    chk("R3 pending miss", int'(rsp_hit_o), 0);
    chk("R3 pending way", int'(rsp_way_o), 0);
    probe_expect("R3 denied still touches", 'h050, 1, 'h020);
    issue(OP_TOUCH, 'h020); chk("R10 touch err", int'(rsp_err_o), 0);
    probe_expect("R10 touch moves victim", 'h050, 2, 'h030);
  endtask

  task automatic t_perm();
    issue(OP_PERM_WR, 'h030, REQ_LOAD, PERM_RDONLY); chk("R8 write err", int'(rsp_err_o), 0);
    issue(OP_PERM_RD, 'h030); chk("R8 read back", int'(rsp_perm_o), 2);
    issue(OP_ACCESS, 'h030, REQ_LOAD);  chk("R2 ro load", int'(rsp_hit_o), 1);
    issue(OP_ACCESS, 'h030, REQ_FETCH); chk("R2 ro fetch", int'(rsp_hit_o), 1);
    issue(OP_ACCESS, 'h030, REQ_STORE); chk("R2 ro store", int'(rsp_hit_o), 0);
    issue(OP_PERM_WR, 'h040, REQ_LOAD, PERM_RDWR);
    issue(OP_ACCESS, 'h040, REQ_STORE); chk("R2 rw store", int'(rsp_hit_o), 1);
    issue(OP_ACCESS, 'h040, REQ_LOAD);  chk("R2 rw load", int'(rsp_hit_o), 1);
    probe_expect("R9 after accesses", 'h050, 0, 'h010);
  endtask

  task automatic t_absent_err();
    issue(OP_DEALLOC, 'h090); chk("R11 dealloc absent", int'(rsp_err_o), 1);
    issue(OP_PERM_RD, 'h090); chk("R11 read absent", int'(rsp_err_o), 1);
    issue(OP_PERM_WR, 'h090, REQ_LOAD, PERM_RDWR); chk("R11 write absent", int'(rsp_err_o), 1);
    issue(OP_TOUCH, 'h090); chk("R11 touch absent", int'(rsp_err_o), 1);
    probe_expect("R11 order kept", 'h050, 0, 'h010);
    issue(OP_PERM_RD, 'h030); chk("R11 perm kept", int'(rsp_perm_o), 2);
  endtask

  task automatic t_dealloc();
    issue(OP_DEALLOC, 'h010);
    chk("R7 dealloc err", int'(rsp_err_o), 0);
    chk("R7 dealloc way", int'(rsp_way_o), 0);
    issue(OP_PRESENT, 'h010); chk("R7 gone", int'(rsp_hit_o), 0);
    probe_expect("R7 tag kept", 'h050, 0, 'h010);
    issue(OP_AVAIL, 'h050); chk("R4 free avail", int'(rsp_hit_o), 1);
    issue(OP_ALLOC, 'h050); chk("R5 reuse lowest free", int'(rsp_way_o), 0);
    probe_expect("R5 alloc touches", 'h050, 1, 'h020);
    issue(OP_ALLOC, 'h050); chk("R6 duplicate err", int'(rsp_err_o), 1);
  endtask

  task automatic t_sets();
    issue(OP_PRESENT, 'h051); chk("R13 other set empty", int'(rsp_hit_o), 0);
    issue(OP_ALLOC, 'h011);
    chk("R13 set1 way", int'(rsp_way_o), 0);
    chk("R13 set1 err", int'(rsp_err_o), 0);
    probe_expect("R13 set1 own order", 'h011, 3, 'h000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_pending_touch();
    t_perm();
    t_absent_err();
    t_dealloc();
    t_sets();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule